// File: doc/BRIEF.md
# Memory wait-state controller

This block decides how many wait states each memory access in a small 8-bit microcontroller receives, and then stretches the bus cycle by that amount. The core raises `req` along with a space code and a flag marking a data-space move. The block picks a wait count from a three-bit field and a few override bits. It multiplies that count by the per-access clocks-per-wait value and asserts `ready` once that many clocks have passed.

Internal RAM never waits. Internal ROM can be forced to zero waits. A data-space move to external read/write memory can be forced to a fixed count. External ROM always follows the field. Software sets these options through a small byte-wide register port. The same registers also hold the enable for the timer clock.

Top module: `mem_wait_ctrl`

## Requirements
- R1: An access to external ROM (space code 2) uses the wait field, bits [7:5] of the register at 0xFC. It completes after field × `cpw` clocks.
- R2: An access to internal RAM (space code 0) always has zero wait states, whatever the register contents.
- R3: An access to internal ROM (space code 1) has zero waits when bit 7 of the register at 0xD6 is 1, and field × `cpw` clocks when that bit is 0.
- R4: An access to external data space (space code 3) with `xmove`=1, bit 5 of 0xD6 set and bit 4 of 0xD2 set uses exactly 4 waits (4 × `cpw` clocks). In every other case it uses the field.
- R5: `tmr_clk_en` equals bit 6 of the register at 0xD6. It takes the new value in the clock after that register is written.
- R6: Reset clears the wait field, bits 7..5 of 0xD6 and bit 4 of 0xD2. After reset, every register reads 0, `tmr_clk_en` is 0, and every access completes with zero waits.
- R7: For a total of N > 0 clocks, a request accepted in cycle 0 gives `ready` high for exactly one cycle, in cycle N. For N = 0, `ready` is high in the same cycle as the request.
- R8: The wait total is captured when the request is accepted. A register write during an access does not change the length of that access.
- R9: A request raised while an access is still in progress is ignored. It neither ends the current access early nor starts a new one.
- R10: The registers read back on `reg_rdata` combinationally for the address on `reg_addr`, with the implemented bits in place and all other bits 0:
  - 0xFC gives {field, 5'b0}.
  - 0xD6 gives {bit7, bit6, bit5, 5'b0}.
  - 0xD2 gives {3'b0, bit4, 4'b0}.
  - Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, accepted when idle |
| space | input | 2 | 0 internal RAM, 1 internal ROM, 2 external ROM, 3 external data space |
| xmove | input | 1 | Access is a data-space move instruction |
| cpw | input | 3 | Clocks added per wait state for this access |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| ready | output | 1 | Access complete |
| busy | output | 1 | Access in progress |
| tmr_clk_en | output | 1 | Timer clock enable |

## Verification
A wrong selection of wait count shows up as an access latency that is off by a whole multiple of `cpw`, which the bench measures from the cycle of the request to the cycle of `ready`. A counter that loads or decrements wrongly shows the same way within the length of one access. A stuck busy flag makes the next zero-wait access fail to return `ready` in its own cycle. Register bits in the wrong position show immediately on the combinational read port, and in the next access's latency.

// File: rtl/mem_wait_ctrl.sv
module mem_wait_ctrl #(
  parameter int WS_W        = 3,
  parameter int CPW_W       = 3,
  parameter int FIXED_WAITS = 4,
  parameter logic [7:0] WS_ADDR  = 8'hFC,
  parameter logic [7:0] CTL_ADDR = 8'hD6,
  parameter logic [7:0] CFG_ADDR = 8'hD2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [1:0]       space,
  input  logic             xmove,
  input  logic [CPW_W-1:0] cpw,
  input  logic             reg_we,
  input  logic [7:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             ready,
  output logic             busy,
  output logic             tmr_clk_en
);
  localparam int CNT_W = WS_W + CPW_W;

  logic [WS_W-1:0]  ws_field;
  logic             rom_fast, tmr_on, xdata_fixed;
  logic             rw_sel;
  logic [WS_W-1:0]  waits;
  logic [CNT_W-1:0] total, cnt;
  logic             accept;
  logic             unused_bits;

  assign unused_bits = ^reg_wdata[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_field    <= '0;
      rom_fast    <= 1'b0;
      tmr_on      <= 1'b0;
      xdata_fixed <= 1'b0;
      rw_sel      <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        WS_ADDR:  ws_field <= reg_wdata[7 -: WS_W];
        CTL_ADDR: begin
          rom_fast    <= reg_wdata[7];
          tmr_on      <= reg_wdata[6];
          xdata_fixed <= reg_wdata[5];
        end
        CFG_ADDR: rw_sel <= reg_wdata[4];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      WS_ADDR:  reg_rdata[7 -: WS_W] = ws_field;
      CTL_ADDR: reg_rdata[7:5] = {rom_fast, tmr_on, xdata_fixed};
      CFG_ADDR: reg_rdata[4] = rw_sel;
      default: ;
    endcase
  end

  always_comb begin
    case (space)
      2'd0:    waits = '0;
      2'd1:    waits = rom_fast ? '0 : ws_field;
      2'd2:    waits = ws_field;
      default: waits = (xmove && xdata_fixed && rw_sel) ? WS_W'(FIXED_WAITS) : ws_field;
    endcase
  end

  assign total      = CNT_W'(waits) * CNT_W'(cpw);
  assign accept     = req && !busy;
  assign ready      = (accept && total == '0) || (busy && cnt == CNT_W'(1));
  assign tmr_clk_en = tmr_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (accept && total != '0) begin
      cnt  <= total;
      busy <= 1'b1;
    end else if (busy) begin
      cnt <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/mem_wait_ctrl_chk.sv
module mem_wait_ctrl_chk #(
  parameter int WS_W = 3,
  parameter int CPW_W = 3,
  parameter logic [7:0] CTL_ADDR = 8'hD6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic [1:0]       space,
  input logic             xmove,
  input logic [CPW_W-1:0] cpw,
  input logic             reg_we,
  input logic [7:0]       reg_addr,
  input logic [7:0]       reg_wdata,
  input logic             ready,
  input logic             busy,
  input logic             tmr_clk_en,
  input logic [WS_W-1:0]  ws_field,
  input logic             rom_fast,
  input logic             xdata_fixed,
  input logic             rw_sel
);
  a_r2_ram_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy && space == 2'd0) |-> ready);

  a_r3_rom_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy && space == 2'd1 && rom_fast) |-> ready);

  a_r1_zero_field: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy && space == 2'd2 && ws_field == '0) |-> ready);

  a_r4_fixed_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy && space == 2'd3 && xmove && xdata_fixed && rw_sel && cpw != '0) |-> !ready);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ready) |=> !busy);

  a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ready) |=> busy);

  a_r5_timer_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == CTL_ADDR) |=> (tmr_clk_en == $past(reg_wdata[6])));
endmodule

bind mem_wait_ctrl mem_wait_ctrl_chk #(.WS_W(WS_W), .CPW_W(CPW_W), .CTL_ADDR(CTL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .space(space), .xmove(xmove), .cpw(cpw),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ready(ready),
  .busy(busy), .tmr_clk_en(tmr_clk_en), .ws_field(ws_field), .rom_fast(rom_fast),
  .xdata_fixed(xdata_fixed), .rw_sel(rw_sel)
);

// File: tb/tb_mem_wait_ctrl.sv
`timescale 1ns/1ps
module tb_mem_wait_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req = 1'b0, xmove = 1'b0, reg_we = 1'b0;
  logic [1:0] space = 2'd0;
  logic [2:0] cpw = 3'd0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ready, busy, tmr_clk_en;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  mem_wait_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req(req), .space(space), .xmove(xmove), .cpw(cpw),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ready(ready), .busy(busy), .tmr_clk_en(tmr_clk_en)
  );

  // {field, ctl7/6/5, cfg4, space, xmove, cpw, expected clocks}
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {3'd7, 3'b000, 1'b0, 2'd0, 1'b0, 3'd4, 8'd0},   // R2
    {3'd3, 3'b000, 1'b0, 2'd1, 1'b0, 3'd3, 8'd9},   // R3
    {3'd3, 3'b100, 1'b0, 2'd1, 1'b0, 3'd3, 8'd0},   // R3
    {3'd5, 3'b100, 1'b0, 2'd2, 1'b0, 3'd4, 8'd20},  // R1
    {3'd2, 3'b001, 1'b1, 2'd3, 1'b1, 3'd4, 8'd16},  // R4
    {3'd2, 3'b001, 1'b0, 2'd3, 1'b1, 3'd4, 8'd8},   // R4
    {3'd2, 3'b001, 1'b1, 2'd3, 1'b0, 3'd3, 8'd6},   // R4
    {3'd6, 3'b000, 1'b1, 2'd3, 1'b1, 3'd4, 8'd24},  // R4
    {3'd7, 3'b000, 1'b0, 2'd2, 1'b0, 3'd7, 8'd49},  // R1
    {3'd0, 3'b000, 1'b0, 2'd2, 1'b0, 3'd4, 8'd0},   // R1
    {3'd0, 3'b001, 1'b1, 2'd3, 1'b1, 3'd3, 8'd12},  // R4
    {3'd1, 3'b000, 1'b0, 2'd2, 1'b0, 3'd0, 8'd0}    // R7
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic access(input logic [1:0] sp, input logic xm, input logic [2:0] c,
                        output int lat, output int after);
    @(negedge clk);
    space = sp; xmove = xm; cpw = c; req = 1'b1;
    #1 lat = 0;
    if (!ready) begin
      do begin
        @(negedge clk);
        req = 1'b0;
        lat++;
        #1;
      end while (!ready && lat < 200);
    end
    req = 1'b0;
    @(negedge clk);
    #1 after = (busy || ready) ? 1 : 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int lat, after;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6 reset state
    rd(8'hFC, d); check("R6 field reset", d, 0);
    rd(8'hD6, d); check("R6 ctl reset", d, 0);
    rd(8'hD2, d); check("R6 cfg reset", d, 0);
    check("R6 timer off", tmr_clk_en, 0);
    access(2'd3, 1'b1, 3'd7, lat, after); check("R6 zero waits after reset", lat, 0);

    for (int i = 0; i < NV; i++) begin
      wr(8'hFC, {VEC[i][20:18], 5'b0});
      wr(8'hD6, {VEC[i][17:15], 5'b0});
      wr(8'hD2, {3'b0, VEC[i][14], 4'b0});
      access(VEC[i][13:12], VEC[i][11], VEC[i][10:8], lat, after);
      check($sformatf("R1-R4 vector %0d latency", i), lat, int'(VEC[i][7:0]));
      check($sformatf("R7 vector %0d single pulse", i), after, 0);
    end

    // R10 readback and unmapped address
    wr(8'hFC, 8'hBF); rd(8'hFC, d); check("R10 field readback", d, 8'hA0);
    wr(8'hD6, 8'hFF); rd(8'hD6, d); check("R10 ctl readback", d, 8'hE0);
    wr(8'hD2, 8'hFF); rd(8'hD2, d); check("R10 cfg readback", d, 8'h10);
    wr(8'h55, 8'hFF); rd(8'h55, d); check("R10 unmapped reads zero", d, 0);
    rd(8'hFC, d); check("R10 unmapped write no effect", d, 8'hA0);

    // R5 timer enable follows bit 6
    check("R5 timer on", tmr_clk_en, 1);
    wr(8'hD6, 8'hA0); check("R5 timer off", tmr_clk_en, 0);

    // R8 / R9: field 2, cpw 3 -> 6 clocks; write field 7 and raise a RAM request mid-access
    wr(8'hFC, 8'h40);
    @(negedge clk);
    space = 2'd2; xmove = 1'b0; cpw = 3'd3; req = 1'b1;
    #1 check("R7 nonzero not ready at request", ready, 0);
    @(negedge clk);
    space = 2'd0; req = 1'b1;
    reg_we = 1'b1; reg_addr = 8'hFC; reg_wdata = 8'hE0;
    #1 check("R9 request while busy ignored", ready, 0);
    lat = 1;
    do begin
      @(negedge clk);
      req = 1'b0; reg_we = 1'b0;
      lat++;
      #1;
    end while (!ready && lat < 200);
    check("R8 latched wait total", lat, 6);
    @(negedge clk);
    #1 check("R9 no extra access started", busy, 0);
    rd(8'hFC, d); check("R8 write during access applied", d, 8'hE0);
    access(2'd2, 1'b0, 3'd1, lat, after); check("R8 next access uses new field", lat, 7);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule